// File: doc/BRIEF.md
# Flash Command Decoder with Read-Mode Steering

This block is the command front end of a 16-bit flash device. Every write cycle on a synchronous bus brings an address and a data word. The block decodes the low byte of the data as a command code. Some commands finish in one cycle: they switch the read mode, clear the error flags, or pause or restart the embedded sequencer. Other commands need two cycles. The first cycle is a setup code and the second is a confirm code or a data word. The address of the second cycle must match the address of the first.

Accepted erase and program commands go out as one-cycle request pulses to the sequencer. Lock commands go out the same way to the lock controller. The block holds the current read mode. From that mode and the read address it tells the output multiplexer which source to present: the array, the status word, the query table, a constant identifier word, the one-time-programmable area, or the lock configuration of the addressed block. After any accepted erase or program, the read mode becomes status and stays there until software asks for the array again.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the read mode is array (code 0), the error flags are 00, and no request pulse is active.
- R2: Only the low byte of a write in idle is decoded. FFh, 90h, 98h and 70h set the read mode to array (0), identifier (1), query (2) and status (3).
- R3: 50h pulses `clr_req`, clears both error flags and leaves the read mode as it was.
- R4: When no setup is pending, B0h pulses `susp_req` and leaves the read mode unchanged. D0h pulses `resume_req` and sets the read mode to status.
- R5: 20h then D0h requests a block erase (`seq_op` 0). 30h then D0h requests a full chip erase (`seq_op` 1). Either sets the read mode to status.
- R6: 40h or 10h, followed by any data word, requests a program (`seq_op` 2). `op_data` carries that data word and the read mode becomes status.
- R7: 60h followed by 01h, D0h or 2Fh requests set lock, clear lock or set lock-down (`lock_op` 0, 1, 2). The read mode does not change.
- R8: C0h followed by data requests an OTP program (`seq_op` 3) only when the address lies in 80h..88h. Any other address is an invalid sequence.
- R9: A second cycle whose address differs from the first cycle's address is an invalid sequence. `op_addr` carries the setup address.
- R10: An invalid sequence sets both error flags to 11, sets the read mode to status and issues no request.
- R11: An undefined code written in idle causes no pulse, no mode change and no flag change.
- R12: In identifier mode the source is chosen from the read address:
  - address 0 gives constant 00B0h (`rd_src` 3);
  - address 1 gives constant 00A4h;
  - addresses 80h..88h give OTP (4);
  - block base plus 2 gives lock (5);
  - any other address gives constant 0.
  Blocks are 4K words from F8000h up, 32K words from F0000h to F7FFFh, and 64K words below F0000h. In the other modes the source is array (0), status (1) or query (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | A write cycle is present this clock |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data; the low byte is the command code |
| rd_addr | input | 20 | Read address used for source steering |
| rd_mode | output | 2 | Current read mode |
| rd_src | output | 3 | Output multiplexer source select |
| rd_const | output | 16 | Constant word presented when `rd_src` is 3 |
| seq_req | output | 1 | One-cycle erase or program request |
| seq_op | output | 2 | Kind of sequencer request |
| lock_req | output | 1 | One-cycle lock request |
| lock_op | output | 2 | Kind of lock request |
| op_addr | output | 20 | Address of the request |
| op_data | output | 16 | Data word of the request |
| susp_req | output | 1 | Suspend pulse |
| resume_req | output | 1 | Resume pulse |
| clr_req | output | 1 | Clear-status pulse |
| err_flags | output | 2 | Sticky invalid-sequence flags |

## Verification
The bench targets the following corner cases:
- **Second cycle of a setup.** A D0h or 01h that arrives as the second cycle must be taken as a confirm, not as a fresh command. A decoder that got this wrong would emit a resume pulse or drop the request.
- **Address mismatch and OTP range.** Confirms are sent with a mismatched address, and OTP programs are sent at 88h (inside the range) and 89h (outside it). A decoder that checked the address loosely would issue requests it should reject.
- **Program data that looks like a command.** FFh is used as program data. A decoder that parsed it as a command would switch to array mode instead of programming.
- **Block boundaries in identifier mode.** Lock-word reads are placed on each block-size boundary. A decoder with the wrong block size would point the multiplexer at a constant instead of the lock source.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0, MODE_ID = 2'd1, MODE_QUERY = 2'd2, MODE_STATUS = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ERASE, ST_CHIP, ST_PROG, ST_LOCK, ST_OTP
    } cstate_e;

    typedef enum logic [3:0] {
        K_NONE, K_RD_ARRAY, K_RD_ID, K_RD_QRY, K_RD_STAT, K_CLR, K_SUSP, K_CONF,
        K_S_ERASE, K_S_CHIP, K_S_PROG, K_S_LOCK, K_S_OTP, K_LK_SET, K_LK_DOWN
    } code_e;

    typedef enum logic [1:0] {
        SOP_BLK_ERASE = 2'd0, SOP_CHIP_ERASE = 2'd1, SOP_PROGRAM = 2'd2, SOP_OTP = 2'd3
    } seqop_e;

    typedef enum logic [1:0] {
        LOP_SET = 2'd0, LOP_CLEAR = 2'd1, LOP_DOWN = 2'd2
    } lockop_e;

    typedef enum logic [2:0] {
        SRC_ARRAY = 3'd0, SRC_STATUS = 3'd1, SRC_QUERY = 3'd2,
        SRC_CONST = 3'd3, SRC_OTP = 3'd4, SRC_LOCK = 3'd5
    } rsrc_e;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
    import flcmd_pkg::*;
(
    input  logic [7:0] code,
    output code_e      kind
);
    always_comb begin
        case (code)
            8'hFF:        kind = K_RD_ARRAY;
            8'h90:        kind = K_RD_ID;
            8'h98:        kind = K_RD_QRY;
            8'h70:        kind = K_RD_STAT;
            8'h50:        kind = K_CLR;
            8'hB0:        kind = K_SUSP;
            8'hD0:        kind = K_CONF;
            8'h20:        kind = K_S_ERASE;
            8'h30:        kind = K_S_CHIP;
            8'h40, 8'h10: kind = K_S_PROG;
            8'h60:        kind = K_S_LOCK;
            8'hC0:        kind = K_S_OTP;
            8'h01:        kind = K_LK_SET;
            8'h2F:        kind = K_LK_DOWN;
            default:      kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/cui_core.sv
module cui_core
    import flcmd_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int OTP_LO = 'h80,
    parameter int OTP_HI = 'h88
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  code_e         kind,
    output rmode_e        mode,
    output logic [1:0]    err,
    output logic          seq_req,
    output seqop_e        seq_op,
    output logic          lock_req,
    output lockop_e       lock_op,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          susp_req,
    output logic          resume_req,
    output logic          clr_req
);
    typedef struct packed {
        cstate_e       state;
        logic [AW-1:0] addr_lat;
        rmode_e        mode;
        logic [1:0]    err;
        logic          seq_req;
        seqop_e        seq_op;
        logic          lock_req;
        lockop_e       lock_op;
        logic [AW-1:0] op_addr;
        logic [DW-1:0] op_data;
        logic          susp;
        logic          resume;
        logic          clr;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state: ST_IDLE, addr_lat: '0, mode: MODE_ARRAY, err: 2'b00,
        seq_req: 1'b0, seq_op: SOP_BLK_ERASE, lock_req: 1'b0, lock_op: LOP_SET,
        op_addr: '0, op_data: '0, susp: 1'b0, resume: 1'b0, clr: 1'b0};

    regs_t r_d, r_q;
    logic  same_addr, in_otp, good, is_seq;
    seqop_e  sop;
    lockop_e lop;

    assign same_addr = (wr_addr == r_q.addr_lat);
    assign in_otp    = (int'(r_q.addr_lat) >= OTP_LO) && (int'(r_q.addr_lat) <= OTP_HI);

    always_comb begin
        r_d          = r_q;
        r_d.seq_req  = 1'b0;
        r_d.lock_req = 1'b0;
        r_d.susp     = 1'b0;
        r_d.resume   = 1'b0;
        r_d.clr      = 1'b0;
        good         = 1'b0;
        is_seq       = 1'b1;
        sop          = SOP_BLK_ERASE;
        lop          = LOP_SET;
        if (wr_en) begin
            if (r_q.state == ST_IDLE) begin
                r_d.addr_lat = wr_addr;
                case (kind)
                    K_RD_ARRAY: r_d.mode = MODE_ARRAY;
                    K_RD_ID:    r_d.mode = MODE_ID;
                    K_RD_QRY:   r_d.mode = MODE_QUERY;
                    K_RD_STAT:  r_d.mode = MODE_STATUS;
                    K_CLR:      begin r_d.clr = 1'b1; r_d.err = 2'b00; end
                    K_SUSP:     r_d.susp = 1'b1;
                    K_CONF:     begin r_d.resume = 1'b1; r_d.mode = MODE_STATUS; end
                    K_S_ERASE:  r_d.state = ST_ERASE;
                    K_S_CHIP:   r_d.state = ST_CHIP;
                    K_S_PROG:   r_d.state = ST_PROG;
                    K_S_LOCK:   r_d.state = ST_LOCK;
                    K_S_OTP:    r_d.state = ST_OTP;
                    default:    r_d.addr_lat = r_q.addr_lat;
                endcase
            end else begin
                r_d.state = ST_IDLE;
                case (r_q.state)
                    ST_ERASE: begin good = same_addr && (kind == K_CONF); sop = SOP_BLK_ERASE; end
                    ST_CHIP:  begin good = same_addr && (kind == K_CONF); sop = SOP_CHIP_ERASE; end
                    ST_PROG:  begin good = same_addr; sop = SOP_PROGRAM; end
                    ST_OTP:   begin good = same_addr && in_otp; sop = SOP_OTP; end
                    default: begin
                        is_seq = 1'b0;
                        good   = same_addr && (kind inside {K_LK_SET, K_CONF, K_LK_DOWN});
                        lop    = (kind == K_LK_SET) ? LOP_SET :
                                 (kind == K_CONF)   ? LOP_CLEAR : LOP_DOWN;
                    end
                endcase
                if (!good) begin
                    r_d.err  = 2'b11;
                    r_d.mode = MODE_STATUS;
                end else begin
                    r_d.op_addr = r_q.addr_lat;
                    r_d.op_data = wr_data;
                    if (is_seq) begin
                        r_d.seq_req = 1'b1;
                        r_d.seq_op  = sop;
                        r_d.mode    = MODE_STATUS;
                    end else begin
                        r_d.lock_req = 1'b1;
                        r_d.lock_op  = lop;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign mode       = r_q.mode;
    assign err        = r_q.err;
    assign seq_req    = r_q.seq_req;
    assign seq_op     = r_q.seq_op;
    assign lock_req   = r_q.lock_req;
    assign lock_op    = r_q.lock_op;
    assign op_addr    = r_q.op_addr;
    assign op_data    = r_q.op_data;
    assign susp_req   = r_q.susp;
    assign resume_req = r_q.resume;
    assign clr_req    = r_q.clr;

    // R5
    seq_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |-> mode == MODE_STATUS);
    // R7
    lock_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |-> mode == $past(mode));
    // R4
    susp_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> mode == $past(mode));
    // R10
    err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err == 2'b00) || (err == 2'b11));
    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_req, lock_req, susp_req, resume_req, clr_req}));
    // R10
    err_rise_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err[0]) |-> mode == MODE_STATUS && !seq_req && !lock_req);
endmodule

// File: rtl/rd_steer.sv
module rd_steer
    import flcmd_pkg::*;
#(
    parameter int          AW         = 20,
    parameter int          DW         = 16,
    parameter logic [15:0] MFR_CODE   = 16'h00B0,
    parameter logic [15:0] DEV_CODE   = 16'h00A4,
    parameter int          OTP_LO     = 'h80,
    parameter int          OTP_HI     = 'h88,
    parameter int          PARAM_BASE = 'hF8000,
    parameter int          MID_BASE   = 'hF0000,
    parameter int          PARAM_BITS = 12,
    parameter int          MID_BITS   = 15,
    parameter int          MAIN_BITS  = 16
) (
    input  rmode_e        mode,
    input  logic [AW-1:0] rd_addr,
    output rsrc_e         src,
    output logic [DW-1:0] cword
);
    localparam int LOCK_OFS = 2;
    logic is_lock_word;
    int   a;

    always_comb begin
        a = int'(rd_addr);
        if (a >= PARAM_BASE)    is_lock_word = rd_addr[PARAM_BITS-1:0] == PARAM_BITS'(LOCK_OFS);
        else if (a >= MID_BASE) is_lock_word = rd_addr[MID_BITS-1:0]   == MID_BITS'(LOCK_OFS);
        else                    is_lock_word = rd_addr[MAIN_BITS-1:0]  == MAIN_BITS'(LOCK_OFS);
    end

    always_comb begin
        cword = '0;
        case (mode)
            MODE_ARRAY:  src = SRC_ARRAY;
            MODE_STATUS: src = SRC_STATUS;
            MODE_QUERY:  src = SRC_QUERY;
            default: begin
                if (a == 0) begin
                    src = SRC_CONST; cword = DW'(MFR_CODE);
                end else if (a == 1) begin
                    src = SRC_CONST; cword = DW'(DEV_CODE);
                end else if (a >= OTP_LO && a <= OTP_HI) begin
                    src = SRC_OTP;
                end else if (is_lock_word) begin
                    src = SRC_LOCK;
                end else begin
                    src = SRC_CONST;
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
    import flcmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_mode,
    output logic [2:0]    rd_src,
    output logic [DW-1:0] rd_const,
    output logic          seq_req,
    output logic [1:0]    seq_op,
    output logic          lock_req,
    output logic [1:0]    lock_op,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          susp_req,
    output logic          resume_req,
    output logic          clr_req,
    output logic [1:0]    err_flags
);
    code_e   kind;
    rmode_e  mode;
    seqop_e  sop;
    lockop_e lop;
    rsrc_e   src;

    cmd_classify u_cls (.code(wr_data[7:0]), .kind(kind));

    cui_core #(.AW(AW), .DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .kind(kind), .mode(mode), .err(err_flags), .seq_req(seq_req), .seq_op(sop),
        .lock_req(lock_req), .lock_op(lop), .op_addr(op_addr), .op_data(op_data),
        .susp_req(susp_req), .resume_req(resume_req), .clr_req(clr_req));

    rd_steer #(.AW(AW), .DW(DW)) u_steer (
        .mode(mode), .rd_addr(rd_addr), .src(src), .cword(rd_const));

    assign rd_mode = mode;
    assign seq_op  = sop;
    assign lock_op = lop;
    assign rd_src  = src;

    // R12
    lock_src_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_LOCK || src == SRC_OTP) |-> mode == MODE_ID);
endmodule

// File: tb/sim_flash_cmd_ui.sv
module sim_flash_cmd_ui;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic [1:0]  rd_mode, seq_op, lock_op, err_flags;
    logic [2:0]  rd_src;
    logic [15:0] rd_const, op_data;
    logic [19:0] op_addr;
    logic        seq_req, lock_req, susp_req, resume_req, clr_req;

    always #4 clk = ~clk;

    flash_cmd_ui u0 (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    int m_mode = 0, m_err = 0, m_pend = 0, m_paddr = 0;
    int e_seq = 0, e_sop = 0, e_lock = 0, e_lop = 0, e_addr = 0, e_data = 0;
    int e_susp = 0, e_res = 0, e_clr = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_src(input int md, input int ra);
        int ofs;
        if (md == 0) return 0;
        if (md == 3) return 1;
        if (md == 2) return 2;
        if (ra == 0 || ra == 1) return 3;
        if (ra >= 'h80 && ra <= 'h88) return 4;
        ofs = (ra >= 'hF8000) ? ra % 4096 : (ra >= 'hF0000) ? ra % 32768 : ra % 65536;
        return (ofs == 2) ? 5 : 3;
    endfunction

    function automatic int ref_const(input int ra);
        if (ra == 0) return 'hB0;
        if (ra == 1) return 'hA4;
        return 0;
    endfunction

    task automatic compare_all();
        int es;
        chk("R2 rd_mode", rd_mode, m_mode);
        chk("R10 err_flags", err_flags, m_err);
        chk("R5 seq_req", seq_req, e_seq);
        if (e_seq != 0) begin
            chk("R6 seq_op", seq_op, e_sop);
            chk("R9 op_addr", op_addr, e_addr);
            if (e_sop >= 2) chk("R6 op_data", op_data, e_data);
        end
        chk("R7 lock_req", lock_req, e_lock);
        if (e_lock != 0) begin
            chk("R7 lock_op", lock_op, e_lop);
            chk("R7 op_addr", op_addr, e_addr);
        end
        chk("R3 clr_req", clr_req, e_clr);
        chk("R4 susp_req", susp_req, e_susp);
        chk("R4 resume_req", resume_req, e_res);
        es = ref_src(m_mode, int'(rd_addr));
        chk("R12 rd_src", rd_src, es);
        if (es == 3) chk("R12 rd_const", rd_const, ref_const(int'(rd_addr)));
    endtask

    task automatic model(input bit we, input int a, input int d);
        int b, p;
        bit ok;
        e_seq = 0; e_lock = 0; e_susp = 0; e_res = 0; e_clr = 0;
        if (!we) return;
        b = d & 'hFF;
        if (m_pend == 0) begin
            case (b)
                'hFF: m_mode = 0;
                'h90: m_mode = 1;
                'h98: m_mode = 2;
                'h70: m_mode = 3;
                'h50: begin e_clr = 1; m_err = 0; end
                'hB0: e_susp = 1;
                'hD0: begin e_res = 1; m_mode = 3; end
                'h20, 'h30, 'h40, 'h10, 'h60, 'hC0: begin m_pend = b; m_paddr = a; end
                default: ;
            endcase
        end else begin
            p = m_pend; m_pend = 0; ok = 0;
            if (a == m_paddr) begin
                case (p)
                    'h20: begin ok = (b == 'hD0); e_sop = 0; end
                    'h30: begin ok = (b == 'hD0); e_sop = 1; end
                    'h40, 'h10: begin ok = 1; e_sop = 2; end
                    'hC0: begin ok = (a >= 'h80 && a <= 'h88); e_sop = 3; end
                    default: begin
                        ok = (b == 'h01 || b == 'hD0 || b == 'h2F);
                        e_lop = (b == 'h01) ? 0 : (b == 'hD0) ? 1 : 2;
                    end
                endcase
            end
            if (!ok) begin
                m_err = 3; m_mode = 3;
            end else begin
                e_addr = m_paddr; e_data = d;
                if (p == 'h60) e_lock = 1;
                else begin e_seq = 1; m_mode = 3; end
            end
        end
    endtask

    // compare previous results, then drive and advance the model
    task automatic step(input bit we, input int a, input int d, input int ra);
        @(negedge clk);
        compare_all();
        wr_en = we; wr_addr = 20'(a); wr_data = 16'(d); rd_addr = 20'(ra);
        model(we, a, d);
    endtask

    task automatic wr(input int a, input int d);
        step(1, a, d, 0);
    endtask

    int addrs[12] = '{0, 1, 2, 'h80, 'h84, 'h88, 'h89, 'h10002, 'hF8002, 'hF0002, 'hF1002, 'hFF002};
    int codes[18] = '{'hFF, 'h90, 'h98, 'h70, 'h50, 'hB0, 'hD0, 'h20, 'h30, 'h40, 'h10,
                      'h60, 'hC0, 'h01, 'h2F, 'h00, 'hE8, 'hA5};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0);
        chk("R1 reset mode", rd_mode, 0);
        chk("R1 reset err", err_flags, 0);
        // R2 mode codes, upper byte ignored
        wr(5, 'h1290); step(0, 0, 0, 0);
        chk("R2 id mode", rd_mode, 1);
        // R12 identifier steering across block sizes
        step(0, 0, 0, 0); step(0, 0, 0, 1); step(0, 0, 0, 'h86); step(0, 0, 0, 'h20002);
        step(0, 0, 0, 'hF4002); step(0, 0, 0, 'hF9002); step(0, 0, 0, 'hF8003);
        // R11 undefined code keeps identifier mode
        wr(0, 'hE8); step(0, 0, 0, 0);
        chk("R11 undefined ignored", rd_mode, 1);
        // R7 lock pairs keep mode
        wr('h30000, 'h60); wr('h30000, 'h01); step(0, 0, 0, 0);
        chk("R7 set lock", lock_req, 1);
        wr('h30000, 'h60); wr('h30000, 'h2F);
        wr('h30000, 'h60); wr('h30000, 'hD0); step(0, 0, 0, 0);
        chk("R7 mode kept", rd_mode, 1);
        // R5 block erase then chip erase
        wr('h40000, 'h20); wr('h40000, 'hD0); step(0, 0, 0, 0);
        chk("R5 erase to status", rd_mode, 3);
        wr(7, 'h30); wr(7, 'hD0);
        // R6 program with command-like data
        wr('hFF, 'hFF); wr('h1234, 'h10); wr('h1234, 'hFF); step(0, 0, 0, 0);
        chk("R6 program data", op_data, 'hFF);
        wr(9, 'h40); wr(9, 'hABCD);
        // R8 OTP inside and outside range
        wr('h88, 'hC0); wr('h88, 'h5A5A); step(0, 0, 0, 0);
        chk("R8 otp accepted", seq_req, 1);
        wr('h89, 'hC0); wr('h89, 'h5A5A); step(0, 0, 0, 0);
        chk("R8 otp rejected", err_flags, 3);
        // R3 clear keeps mode
        wr(0, 'h98); wr(0, 'h50); step(0, 0, 0, 0);
        chk("R3 cleared", err_flags, 0);
        chk("R3 mode kept", rd_mode, 2);
        // R9 address mismatch
        wr('h100, 'h20); wr('h101, 'hD0); step(0, 0, 0, 0);
        chk("R9 mismatch flagged", err_flags, 3);
        // R10 wrong confirm
        wr(0, 'h50); wr(0, 'hFF); wr(3, 'h60); wr(3, 'h77); step(0, 0, 0, 0);
        chk("R10 bad confirm mode", rd_mode, 3);
        // R4 suspend and resume
        wr(0, 'hFF); wr(0, 'hB0); step(0, 0, 0, 0);
        chk("R4 suspend keeps array", rd_mode, 0);
        wr(0, 'hD0); step(0, 0, 0, 0);
        chk("R4 resume to status", rd_mode, 3);
        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            int a, c, ra;
            a  = ($urandom % 4 == 0) ? m_paddr : addrs[$urandom % 12];
            c  = codes[$urandom % 18] | (($urandom % 2) << 12);
            ra = addrs[$urandom % 12];
            step(($urandom % 10) < 7, a, c, ra);
        end
        step(0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule